// File: doc/BRIEF.md
# I2C Command Slave Front End

This block sits between a two-wire serial bus and the control logic of an eight-channel converter. It watches the oversampled bus lines and spots START, repeated START and STOP conditions. It answers its own strapped address and, for writes only, a fixed broadcast address. It acknowledges each received byte. Once a complete frame has arrived, it hands the downstream logic a 24-bit command word together with a one-cycle strobe.

A read uses the combined format. The master first writes a command byte and two data bytes. It then issues a repeated START and the read address. The slave answers with the bytes of a register-read port, most significant byte first. When those bytes run out, it returns all-ones bytes.

The bus clock may run at up to 400 kHz. The system clock must be many times faster than that, because both lines pass through a two-flop synchroniser before any edge is judged. Analog pad behaviour, clock stretching and the execution of commands are outside this block.

Top module: `i2c_cmd_slave`

## Requirements
- R1: After reset, `sda_pull_o` and `cmd_valid_o` are low and `cmd_word_o` is zero.
- R2: The own address is `{5'b00100, addr_sel_i}`. A write to it is acknowledged on every one of its three bytes (command, data high, data low). After the third acknowledge clock, `cmd_valid_o` is high for exactly one clock, and `cmd_word_o` = {command, data high, data low}.
- R3: A write to the broadcast address 7'b0010100 (byte 0x28) is acknowledged whatever the value of `addr_sel_i`, and it produces the same command word and strobe as in R2.
- R4: A read to the broadcast address (byte 0x29) is not acknowledged.
- R5: A frame whose address matches neither the own address nor the broadcast address is ignored: SDA is never pulled low and no strobe is produced.
- R6: After a read address byte matching the own address is acknowledged, the slave drives `rd_data_i[15:8]` and then `rd_data_i[7:0]`, MSB first. `rd_cmd_o` holds the command byte of the latest write frame.
- R7: Read bytes requested beyond those two are 0xFF.
- R8: When the master NACKs a read byte, SDA is released and the slave stays idle, pulling SDA at no point, until the next START.
- R9: A fourth write byte is not acknowledged and produces no further strobe.
- R10: A write frame ended by STOP before its third byte produces no strobe, and `cmd_word_o` keeps its earlier value.
- R11: A repeated START in the middle of a write frame restarts address decoding and the byte count, so that the following frame delivers only its own three bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as sensed at the pad |
| sda_i | input | 1 | Serial data line as sensed at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_sel_i | input | 2 | Strap bits forming the low two bits of the own address |
| cmd_word_o | output | 24 | Last complete command word |
| cmd_valid_o | output | 1 | One-clock strobe when `cmd_word_o` is updated |
| rd_cmd_o | output | 8 | Command byte of the latest write frame, selecting read data |
| rd_data_i | input | 16 | Register data served on readback |

## Verification
Writes are sent to the strapped address and to the broadcast address, each with a different strap setting. This shows whether matching uses the strap pins or the fixed broadcast value. Reads are sent to both addresses as well, which separates the read-only restriction on broadcast from ordinary address matching. A foreign address shows whether SDA stays untouched.

The readback sequence acknowledges two bytes, then a third, then NACKs a fourth. This separates data bytes from all-ones padding and checks the release that follows the NACK. Three more frames exercise the byte-count boundary: a frame with a fourth byte, a frame cut short by STOP, and a frame restarted by a repeated START. Together they show that the strobe depends only on three acknowledged bytes within one addressed frame.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WR,
    ST_RD,
    ST_RD_ACK,
    ST_RD_NXT
  } slv_st_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] scl_ff, sda_ff;
  logic          scl_q, sda_q;
  logic          scl_s, sda_s;

  assign scl_s = scl_ff[LAST];
  assign sda_s = sda_ff[LAST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[LAST-1:0], scl_i};
      sda_ff <= {sda_ff[LAST-1:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // data edges while clock stays high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_rd_mux.sv
module i2c_rd_mux #(
  parameter int RD_BYTES = 2,
  parameter int RW       = $clog2(RD_BYTES + 1)
) (
  input  logic [RD_BYTES*8-1:0] rd_data_i,
  input  logic [RW-1:0]         rd_idx_i,
  output logic [7:0]            rd_byte_o
);
  logic [7:0] bytes [RD_BYTES];

  for (genvar g = 0; g < RD_BYTES; g++) begin : g_split
    assign bytes[g] = rd_data_i[(RD_BYTES-1-g)*8 +: 8];
  end

  always_comb begin
    rd_byte_o = 8'hFF;  // padding once data runs out
    for (int i = 0; i < RD_BYTES; i++) begin
      if (rd_idx_i == RW'(i)) rd_byte_o = bytes[i];
    end
  end
endmodule

// File: rtl/i2c_slv_fsm.sv
module i2c_slv_fsm
  import i2c_cmd_pkg::*;
#(
  parameter logic [4:0] ADDR_HI   = 5'b00100,
  parameter logic [6:0] BCAST     = 7'b0010100,
  parameter int         CMD_BYTES = 3,
  parameter int         RD_BYTES  = 2,
  parameter int         RW        = $clog2(RD_BYTES + 1),
  parameter int         CW        = CMD_BYTES * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [1:0]    addr_sel_i,
  input  logic [7:0]    rd_byte_i,
  output logic [RW-1:0] rd_idx_o,
  output logic          sda_pull_o,
  output logic [CW-1:0] cmd_word_o,
  output logic          cmd_valid_o,
  output logic [7:0]    rd_cmd_o
);
  localparam int                 IW     = $clog2(CMD_BYTES + 1);
  localparam logic [IW-1:0]      WR_N   = IW'(CMD_BYTES);
  localparam logic [IW-1:0]      WR_END = IW'(CMD_BYTES - 1);
  localparam logic [RW-1:0]      RD_N   = RW'(RD_BYTES);

  slv_st_e       st, ack_nxt;
  logic          drv, pend;
  logic [2:0]    cnt;
  logic [7:0]    sh;
  logic [IW-1:0] wr_idx;
  logic [RW-1:0] rd_idx;
  logic [CW-1:0] cmd_buf;
  logic [7:0]    rx_byte;
  logic          own_hit, bc_hit;

  assign rx_byte = {sh[6:0], sda_i};
  assign own_hit = rx_byte[7:1] == {ADDR_HI, addr_sel_i};
  assign bc_hit  = (rx_byte[7:1] == BCAST) && !rx_byte[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st          <= ST_IDLE;
      ack_nxt     <= ST_IDLE;
      drv         <= 1'b0;
      pend        <= 1'b0;
      cnt         <= '0;
      sh          <= '0;
      wr_idx      <= '0;
      rd_idx      <= '0;
      cmd_buf     <= '0;
      cmd_word_o  <= '0;
      cmd_valid_o <= 1'b0;
      rd_cmd_o    <= '0;
    end else begin
      cmd_valid_o <= 1'b0;
      if (start_i) begin
        st   <= ST_ADDR;
        cnt  <= '0;
        drv  <= 1'b0;
        pend <= 1'b0;
      end else if (stop_i) begin
        st  <= ST_IDLE;
        drv <= 1'b0;
      end else begin
        unique case (st)
          ST_IDLE: ;
          ST_ADDR: if (scl_rise_i) begin
            sh  <= rx_byte;
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              if (own_hit || bc_hit) begin
                st      <= ST_ACK;
                ack_nxt <= rx_byte[0] ? ST_RD : ST_WR;
                wr_idx  <= '0;
                rd_idx  <= '0;
                pend    <= 1'b0;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_ACK: if (scl_fall_i) begin
            if (!drv) begin
              drv <= 1'b1;
            end else begin
              drv <= 1'b0;
              st  <= ack_nxt;
              cnt <= '0;
              if (pend) begin
                pend        <= 1'b0;
                cmd_valid_o <= 1'b1;
                cmd_word_o  <= cmd_buf;
              end
              if (ack_nxt == ST_RD) begin
                sh  <= rd_byte_i;
                drv <= ~rd_byte_i[7];
              end
            end
          end
          ST_WR: if (scl_rise_i) begin
            sh  <= rx_byte;
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              if (wr_idx != WR_N) begin
                cmd_buf <= {cmd_buf[CW-9:0], rx_byte};
                if (wr_idx == '0) rd_cmd_o <= rx_byte;
                if (wr_idx == WR_END) pend <= 1'b1;
                wr_idx  <= wr_idx + 1'b1;
                st      <= ST_ACK;
                ack_nxt <= ST_WR;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_RD: if (scl_fall_i) begin
            if (cnt == 3'd7) begin
              drv <= 1'b0;
              st  <= ST_RD_ACK;
              if (rd_idx != RD_N) rd_idx <= rd_idx + 1'b1;
            end else begin
              sh  <= {sh[6:0], 1'b0};
              drv <= ~sh[6];
              cnt <= cnt + 3'd1;
            end
          end
          ST_RD_ACK: if (scl_rise_i) begin
            st <= sda_i ? ST_IDLE : ST_RD_NXT;  // NACK ends the read
          end
          ST_RD_NXT: if (scl_fall_i) begin
            sh  <= rd_byte_i;
            drv <= ~rd_byte_i[7];
            cnt <= '0;
            st  <= ST_RD;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_pull_o = drv;
  assign rd_idx_o   = rd_idx;
endmodule

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave #(
  parameter logic [4:0] ADDR_HI   = 5'b00100,
  parameter logic [6:0] BCAST     = 7'b0010100,
  parameter int         SYNC      = 2,
  parameter int         CMD_BYTES = 3,
  parameter int         RD_BYTES  = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_pull_o,
  input  logic [1:0]             addr_sel_i,
  output logic [CMD_BYTES*8-1:0] cmd_word_o,
  output logic                   cmd_valid_o,
  output logic [7:0]             rd_cmd_o,
  input  logic [RD_BYTES*8-1:0]  rd_data_i
);
  localparam int RW = $clog2(RD_BYTES + 1);

  logic          sda_w, rise_w, fall_w, start_w, stop_w;
  logic [RW-1:0] rd_idx_w;
  logic [7:0]    rd_byte_w;

  i2c_bus_sync #(.STAGES(SYNC)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_w),
    .scl_rise_o (rise_w),
    .scl_fall_o (fall_w),
    .start_o    (start_w),
    .stop_o     (stop_w)
  );

  i2c_rd_mux #(.RD_BYTES(RD_BYTES), .RW(RW)) u_mux (
    .rd_data_i (rd_data_i),
    .rd_idx_i  (rd_idx_w),
    .rd_byte_o (rd_byte_w)
  );

  i2c_slv_fsm #(
    .ADDR_HI   (ADDR_HI),
    .BCAST     (BCAST),
    .CMD_BYTES (CMD_BYTES),
    .RD_BYTES  (RD_BYTES),
    .RW        (RW)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sda_i       (sda_w),
    .scl_rise_i  (rise_w),
    .scl_fall_i  (fall_w),
    .start_i     (start_w),
    .stop_i      (stop_w),
    .addr_sel_i  (addr_sel_i),
    .rd_byte_i   (rd_byte_w),
    .rd_idx_o    (rd_idx_w),
    .sda_pull_o  (sda_pull_o),
    .cmd_word_o  (cmd_word_o),
    .cmd_valid_o (cmd_valid_o),
    .rd_cmd_o    (rd_cmd_o)
  );
endmodule

// File: rtl/i2c_cmd_slave_chk.sv
module i2c_cmd_slave_chk #(
  parameter int CW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_i,
  input logic          sda_pull_o,
  input logic          cmd_valid_o,
  input logic [CW-1:0] cmd_word_o,
  input logic          start_i,
  input logic          stop_i
);
  // R2
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  // R2
  strobe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !scl_i);

  // R10
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmd_word_o) |-> cmd_valid_o);

  // R8
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_pull_o);

  // R6
  sda_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_pull_o) && !$past(start_i) && !$past(stop_i)) |-> !scl_i);
endmodule

bind i2c_cmd_slave i2c_cmd_slave_chk #(.CW(CMD_BYTES*8)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_i       (scl_i),
  .sda_pull_o  (sda_pull_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_word_o  (cmd_word_o),
  .start_i     (start_w),
  .stop_i      (stop_w)
);

// File: tb/i2c_cmd_slave_tb.sv
module i2c_cmd_slave_tb;
  localparam int CLK_NS = 10;
  localparam int Q      = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [1:0]  addr_sel = 2'b10;
  logic [15:0] rd_data = 16'hBEEF;
  logic        sda_pull, cmd_valid;
  logic [23:0] cmd_word;
  logic [7:0]  rd_cmd;
  logic        sda_bus;

  int total = 0;
  int bad   = 0;
  int strb_cnt = 0;
  logic [23:0] strb_word = '0;
  logic pull_seen = 1'b0;

  assign sda_bus = sda_m & ~sda_pull;

  always #(CLK_NS/2) clk = ~clk;

  i2c_cmd_slave u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .sda_pull_o  (sda_pull),
    .addr_sel_i  (addr_sel),
    .cmd_word_o  (cmd_word),
    .cmd_valid_o (cmd_valid),
    .rd_cmd_o    (rd_cmd),
    .rd_data_i   (rd_data)
  );

  always @(negedge clk) begin
    if (cmd_valid) begin
      strb_cnt  = strb_cnt + 1;
      strb_word = cmd_word;
    end
    if (sda_pull) pull_seen = 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(2*Q);
      scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    ack = ~sda_bus; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl_m = 1'b1; wq(Q);
      b[i] = sda_bus; wq(Q);
      scl_m = 1'b0;
    end
    wq(Q);
    sda_m = ~give_ack; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0; wq(2);
    sda_m = 1'b1; wq(Q-2);
  endtask

  task automatic t_reset();
    check("R1 pull", 32'(sda_pull), 32'd0);
    check("R1 valid", 32'(cmd_valid), 32'd0);
    check("R1 word", 32'(cmd_word), 32'd0);
  endtask

  task automatic t_write_own();
    logic a0, a1, a2, a3;
    int s0;
    addr_sel = 2'b10;
    s0 = strb_cnt;
    bus_start();
    wr_byte(8'h24, a0);
    wr_byte(8'hA5, a1);
    wr_byte(8'h3C, a2);
    wr_byte(8'h0F, a3);
    bus_stop();
    check("R2 acks", {28'd0, a0, a1, a2, a3}, 32'hF);
    check("R2 strobe count", 32'(strb_cnt - s0), 32'd1);
    check("R2 word", 32'(strb_word), 32'hA53C0F);
  endtask

  task automatic t_write_bcast();
    logic a0, a1, a2, a3;
    int s0;
    addr_sel = 2'b01;
    s0 = strb_cnt;
    bus_start();
    wr_byte(8'h28, a0);
    wr_byte(8'h11, a1);
    wr_byte(8'h22, a2);
    wr_byte(8'h33, a3);
    bus_stop();
    check("R3 acks", {28'd0, a0, a1, a2, a3}, 32'hF);
    check("R3 strobe count", 32'(strb_cnt - s0), 32'd1);
    check("R3 word", 32'(cmd_word), 32'h112233);
  endtask

  task automatic t_bcast_read();
    logic a0;
    bus_start();
    wr_byte(8'h29, a0);
    bus_stop();
    check("R4 bcast read ack", 32'(a0), 32'd0);
  endtask

  task automatic t_foreign();
    logic a0, a1, a2;
    int s0;
    addr_sel = 2'b10;
    s0 = strb_cnt;
    pull_seen = 1'b0;
    bus_start();
    wr_byte(8'h26, a0);
    wr_byte(8'h55, a1);
    wr_byte(8'h66, a2);
    bus_stop();
    check("R5 acks", {29'd0, a0, a1, a2}, 32'd0);
    check("R5 sda untouched", 32'(pull_seen), 32'd0);
    check("R5 no strobe", 32'(strb_cnt - s0), 32'd0);
  endtask

  task automatic t_read();
    logic a0, a1, a2, a3, ax;
    logic [7:0] b0, b1, b2, b3;
    addr_sel = 2'b10;
    rd_data = 16'hBEEF;
    bus_start();
    wr_byte(8'h24, a0);
    wr_byte(8'h47, a1);
    wr_byte(8'h00, a2);
    wr_byte(8'h00, a3);
    bus_start();
    wr_byte(8'h25, ax);
    check("R11 read addr ack after Sr", 32'(ax), 32'd1);
    check("R6 rd_cmd", 32'(rd_cmd), 32'h47);
    rd_byte(1'b1, b0);
    rd_byte(1'b1, b1);
    rd_byte(1'b1, b2);
    rd_byte(1'b0, b3);
    check("R6 byte hi", 32'(b0), 32'hBE);
    check("R6 byte lo", 32'(b1), 32'hEF);
    check("R7 pad 1", 32'(b2), 32'hFF);
    check("R7 pad 2", 32'(b3), 32'hFF);
    pull_seen = 1'b0;
    wr_byte(8'h00, ax);
    check("R8 idle after nack ack", 32'(ax), 32'd0);
    check("R8 idle after nack sda", 32'(pull_seen), 32'd0);
    bus_stop();
  endtask

  task automatic t_extra();
    logic a0, a1, a2, a3, a4;
    int s0;
    s0 = strb_cnt;
    bus_start();
    wr_byte(8'h24, a0);
    wr_byte(8'h12, a1);
    wr_byte(8'h34, a2);
    wr_byte(8'h56, a3);
    wr_byte(8'h78, a4);
    bus_stop();
    check("R9 fourth byte nack", 32'(a4), 32'd0);
    check("R9 one strobe", 32'(strb_cnt - s0), 32'd1);
    check("R9 word", 32'(cmd_word), 32'h123456);
  endtask

  task automatic t_short();
    logic a0, a1, a2;
    int s0;
    s0 = strb_cnt;
    bus_start();
    wr_byte(8'h24, a0);
    wr_byte(8'hDE, a1);
    wr_byte(8'hAD, a2);
    bus_stop();
    check("R10 acks", {29'd0, a0, a1, a2}, 32'h7);
    check("R10 no strobe", 32'(strb_cnt - s0), 32'd0);
    check("R10 word held", 32'(cmd_word), 32'h123456);
  endtask

  task automatic t_restart();
    logic a0, a1, a2, a3, a4, a5;
    int s0;
    s0 = strb_cnt;
    bus_start();
    wr_byte(8'h24, a0);
    wr_byte(8'h99, a1);
    bus_start();
    wr_byte(8'h24, a2);
    wr_byte(8'h01, a3);
    wr_byte(8'h02, a4);
    wr_byte(8'h03, a5);
    bus_stop();
    check("R11 acks", {26'd0, a0, a1, a2, a3, a4, a5}, 32'h3F);
    check("R11 one strobe", 32'(strb_cnt - s0), 32'd1);
    check("R11 word", 32'(cmd_word), 32'h010203);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wq(5);
    t_reset();
    rst_n = 1'b1;
    wq(5);
    t_write_own();
    t_write_bcast();
    t_bcast_read();
    t_foreign();
    t_read();
    t_extra();
    t_short();
    t_restart();
    wq(10);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule